// File: doc/BRIEF.md
# Multi-Channel Converter Scan Sequencer

This block is the digital control core of a multi-channel successive-approximation converter. A start strobe (`cnvst_n`, active low) and a two-bit mode field select how conversions are launched. In internal-scan mode (`mode = 00`) one accepted strobe wakes the converter, visits every requested channel of `ch_mask` in ascending index order, stores one result per channel in a result FIFO and goes idle. In per-strobe mode (`mode = 01`) the low phase of the strobe is the acquisition (track) window and its rising edge launches exactly one conversion on the current channel. Modes `10` and `11` are launched elsewhere, so this block ignores the strobe in those modes.

Averaging folds 1, 4, 8, 16 or 32 conversions of one channel into a single FIFO entry, the sum shifted right by log2 of the count and truncated to 12 bits. The multiplexer moves to the next requested channel only after that entry is written. The analog converter sits outside: the block pulses `conv_start` with a channel number and takes back `conv_done` and `conv_data`. An active-low end-of-conversion flag latches when the work is done and is released by the next falling edge of `cs_n` or `cnvst_n`. A strobe that falls while the block is busy raises a one-cycle protocol error and changes nothing.

The control is a five-state machine. `S_IDLE` waits for a start. `S_WAKE` counts the wake-up delay. `S_TRACK` holds the per-strobe acquisition. `S_CONV` issues the conversion request. `S_WAIT` waits for the converter. The transitions are: idle→wake on an accepted internal-scan start; idle→track on a strobe fall in mode 01; wake→conv when the delay expires; track→conv on a rise after a long enough window; track→idle on a rise after a short window; conv→wait always; wait→conv for more averaging or more channels in mode 00; wait→idle at the end of a scan, or after every conversion in mode 01.

Top module: `adc_scan_seq`

## Requirements
- R1: After reset `eoc_n` is 1, `busy` is 0, `proto_err` is 0 and the FIFO is empty (`fifo_empty` 1, `fifo_count` 0).
- R2: In mode 00 a scan starts only when `cnvst_n` returns high after at least MIN_LOW consecutive low clock samples and `ch_mask` is non-zero. A shorter pulse, or a zero mask, starts nothing.
- R3: A mode-00 scan converts each channel whose `ch_mask` bit is 1, once per averaging group, in ascending index order. It skips unrequested channels and writes one FIFO entry per requested channel. `conv_start` is a single-cycle pulse.
- R4: At the end of a scan (mode 00) or a conversion (mode 01) `eoc_n` goes low. It stays low until a falling edge of `cs_n` or `cnvst_n` is sampled, and is high again in the following cycle.
- R5: In mode 01 a falling `cnvst_n` opens acquisition. On the rise, one conversion starts if the low time was at least ACQ_CYC cycles, or ACQ_CYC+REF_WAKE_CYC cycles when `ref_on` is 0. A shorter window returns to idle with no conversion, no FIFO write and `eoc_n` staying high.
- R6: `avg_sel` encodes the group size: 0→1, 1→4, 2→8, 3→16, 4→32, and any other value→1. One FIFO entry, equal to (sum of the group) >> log2(size) truncated to 12 bits, is written only after a full group.
- R7: In mode 01 the current channel starts at the lowest requested channel after the block has been idle in another mode. After each completed group it advances to the next higher requested channel, wrapping to the lowest.
- R8: In modes 10 and 11 `cnvst_n` starts no scan and no acquisition: `busy` stays 0 and the FIFO is unchanged.
- R9: A `cnvst_n` falling edge in mode 00 or 01 while `busy` is 1 gives a one-cycle `proto_err` pulse. The running scan completes with correct FIFO contents.
- R10: When the FIFO holds FIFO_DEPTH entries, further results are dropped and the stored entries are kept. A read of an empty FIFO is ignored. `fifo_dout` shows the oldest entry.
- R11: `busy` is 1 from the cycle after an accepted start until completion. In mode 00 `conv_start` is first high in cycle W+1 after the edge that samples `cnvst_n` high, where W = WAKE_CYC, plus REF_WAKE_CYC when `ref_on` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode | input | 2 | Launch mode: 00 internal scan, 01 per strobe, 1x strobe ignored |
| ch_mask | input | NCH | Requested channels, bit i = channel i |
| avg_sel | input | 3 | Averaging group size code |
| ref_on | input | 1 | Reference already awake; 0 adds REF_WAKE_CYC to the wake/acquisition times |
| cnvst_n | input | 1 | Active-low start strobe, synchronous to clk |
| cs_n | input | 1 | Serial select; its falling edge releases `eoc_n` |
| conv_start | output | 1 | One-cycle conversion request to the converter |
| conv_ch | output | $clog2(NCH) | Channel the multiplexer selects |
| conv_done | input | 1 | Converter result valid (one cycle) |
| conv_data | input | DW | Converter result |
| fifo_rd | input | 1 | Pop the oldest FIFO entry |
| fifo_dout | output | DW | Oldest FIFO entry |
| fifo_empty | output | 1 | FIFO empty |
| fifo_count | output | $clog2(FIFO_DEPTH+1) | Number of stored entries |
| eoc_n | output | 1 | Sticky active-low end of conversion |
| busy | output | 1 | Sequencer not idle |
| proto_err | output | 1 | One-cycle pulse for a strobe that arrived while busy |

## Verification
Internal scans are swept over all fifteen non-zero channel masks, which separates ordering, skipping and entry-count errors. All averaging codes are then run over a sparse and a single-channel mask, so a wrong shift or a wrong group length gives a different value. Every converter sample is a distinct function of channel and sample index, so any extra, missing or reordered conversion shows up in the data. Strobe lengths one cycle short of each threshold, with the reference both awake and asleep, check the acceptance limits. A strobe during a long scan checks the error pulse. Three scans without reading check the drop-on-full rule.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

    typedef enum logic [2:0] {
        S_IDLE,
        S_WAKE,
        S_TRACK,
        S_CONV,
        S_WAIT
    } seq_state_t;

    localparam logic [1:0] MODE_INT = 2'b00;
    localparam logic [1:0] MODE_EXT = 2'b01;

    // group size code -> log2 of the group size
    function automatic logic [2:0] avg_shift(input logic [2:0] sel);
        unique case (sel)
            3'd1:    return 3'd2;
            3'd2:    return 3'd3;
            3'd3:    return 3'd4;
            3'd4:    return 3'd5;
            default: return 3'd0;
        endcase
    endfunction

endpackage

// File: rtl/adc_cnv_filter.sv
module adc_cnv_filter #(
    parameter int CNTW = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cnvst_n,
    output logic [CNTW-1:0] low_cnt,
    output logic            rise,
    output logic            fall
);
    logic prev;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev    <= 1'b1;
            low_cnt <= '0;
        end else begin
            prev <= cnvst_n;
            if (cnvst_n)
                low_cnt <= '0;
            else if (low_cnt != '1)
                low_cnt <= low_cnt + 1'b1;
        end
    end

    assign rise = cnvst_n & ~prev;
    assign fall = ~cnvst_n & prev;
endmodule

// File: rtl/adc_avg_acc.sv
module adc_avg_acc
    import adc_seq_pkg::*;
#(
    parameter int DW   = 12,
    parameter int SUMW = DW + 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          add,
    input  logic [DW-1:0] din,
    input  logic [2:0]    sel,
    output logic          last,
    output logic [DW-1:0] avg
);
    logic [SUMW-1:0] sum, sum_nx;
    logic [5:0]      cnt, target;
    logic [2:0]      sh;

    always_comb begin
        sh     = avg_shift(sel);
        target = 6'd1 << sh;
        sum_nx = sum + SUMW'(din);
        last   = add && ((cnt + 6'd1) >= target);
        avg    = DW'(sum_nx >> sh);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sum <= '0;
            cnt <= '0;
        end else if (clr || last) begin
            sum <= '0;
            cnt <= '0;
        end else if (add) begin
            sum <= sum_nx;
            cnt <= cnt + 6'd1;
        end
    end
endmodule

// File: rtl/adc_res_fifo.sv
module adc_res_fifo #(
    parameter int DW    = 12,
    parameter int DEPTH = 8,
    localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic [DW-1:0] din,
    input  logic          pop,
    output logic [DW-1:0] dout,
    output logic          empty,
    output logic [CW-1:0] count
);
    logic [DW-1:0] mem [DEPTH];
    logic [AW-1:0] wr, rd;
    logic          do_push, do_pop;

    assign do_push = push && (count != CW'(DEPTH));
    assign do_pop  = pop && (count != '0);
    assign empty   = (count == '0);
    assign dout    = mem[rd];

    always_ff @(posedge clk) begin
        if (do_push) mem[wr] <= din;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr    <= '0;
            rd    <= '0;
            count <= '0;
        end else begin
            if (do_push) wr <= (wr == AW'(DEPTH - 1)) ? '0 : wr + 1'b1;
            if (do_pop)  rd <= (rd == AW'(DEPTH - 1)) ? '0 : rd + 1'b1;
            unique case ({do_push, do_pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end
endmodule

// File: rtl/adc_scan_seq.sv
module adc_scan_seq
    import adc_seq_pkg::*;
#(
    parameter int NCH          = 4,
    parameter int DW           = 12,
    parameter int FIFO_DEPTH   = 8,
    parameter int MIN_LOW      = 3,
    parameter int ACQ_CYC      = 6,
    parameter int WAKE_CYC     = 2,
    parameter int REF_WAKE_CYC = 5,
    localparam int CHW     = (NCH > 1) ? $clog2(NCH) : 1,
    localparam int FCW     = $clog2(FIFO_DEPTH + 1),
    localparam int LOW_MAX = (MIN_LOW > ACQ_CYC + REF_WAKE_CYC) ? MIN_LOW : ACQ_CYC + REF_WAKE_CYC,
    localparam int LCW     = $clog2(LOW_MAX + 1),
    localparam int WCW     = $clog2(WAKE_CYC + REF_WAKE_CYC + 1)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [1:0]     mode,
    input  logic [NCH-1:0] ch_mask,
    input  logic [2:0]     avg_sel,
    input  logic           ref_on,
    input  logic           cnvst_n,
    input  logic           cs_n,
    output logic           conv_start,
    output logic [CHW-1:0] conv_ch,
    input  logic           conv_done,
    input  logic [DW-1:0]  conv_data,
    input  logic           fifo_rd,
    output logic [DW-1:0]  fifo_dout,
    output logic           fifo_empty,
    output logic [FCW-1:0] fifo_count,
    output logic           eoc_n,
    output logic           busy,
    output logic           proto_err
);
    seq_state_t     state, state_n;
    logic [WCW-1:0] wcnt, wcnt_n, wake_len;
    logic [CHW-1:0] ptr, ptr_n, ptr_inc;
    logic [LCW-1:0] low_cnt, acq_len;
    logic           rise, fall, cs_prev, eoc_q, proto_q;
    logic           acc_clr, acc_add, acc_last, push, finish, start_int, more_above;
    logic [DW-1:0]  avg_val;

    // lowest requested channel at or after 'from', wrapping
    function automatic logic [CHW-1:0] next_req(input logic [NCH-1:0] m, input logic [CHW-1:0] from);
        logic [CHW-1:0] r;
        logic           found;
        r     = from;
        found = 1'b0;
        for (int i = 0; i < NCH; i++) begin
            int idx;
            idx = (int'(from) + i) % NCH;
            if (!found && m[idx]) begin
                r     = CHW'(idx);
                found = 1'b1;
            end
        end
        return r;
    endfunction

    adc_cnv_filter #(.CNTW(LCW)) u_filt (
        .clk(clk), .rst_n(rst_n), .cnvst_n(cnvst_n),
        .low_cnt(low_cnt), .rise(rise), .fall(fall)
    );

    adc_avg_acc #(.DW(DW)) u_acc (
        .clk(clk), .rst_n(rst_n), .clr(acc_clr), .add(acc_add),
        .din(conv_data), .sel(avg_sel), .last(acc_last), .avg(avg_val)
    );

    adc_res_fifo #(.DW(DW), .DEPTH(FIFO_DEPTH)) u_fifo (
        .clk(clk), .rst_n(rst_n), .push(push), .din(avg_val),
        .pop(fifo_rd), .dout(fifo_dout), .empty(fifo_empty), .count(fifo_count)
    );

    always_comb begin
        wake_len  = ref_on ? WCW'(WAKE_CYC) : WCW'(WAKE_CYC + REF_WAKE_CYC);
        acq_len   = ref_on ? LCW'(ACQ_CYC) : LCW'(ACQ_CYC + REF_WAKE_CYC);
        start_int = (mode == MODE_INT) && rise && (low_cnt >= LCW'(MIN_LOW)) && (|ch_mask);
        ptr_inc   = CHW'((int'(ptr) + 1) % NCH);
        more_above = 1'b0;
        for (int i = 0; i < NCH; i++)
            if (i > int'(ptr) && ch_mask[i]) more_above = 1'b1;
    end

    // next-state and datapath control
    always_comb begin
        state_n = state;
        wcnt_n  = wcnt;
        ptr_n   = ptr;
        acc_clr = 1'b0;
        acc_add = 1'b0;
        push    = 1'b0;
        finish  = 1'b0;
        unique case (state)
            S_IDLE: begin
                if (mode != MODE_EXT) begin
                    ptr_n   = '0;
                    acc_clr = 1'b1;
                end
                if (start_int) begin
                    ptr_n   = next_req(ch_mask, '0);
                    wcnt_n  = wake_len;
                    state_n = S_WAKE;
                end else if (mode == MODE_EXT && fall && (|ch_mask)) begin
                    ptr_n   = next_req(ch_mask, ptr);
                    state_n = S_TRACK;
                end
            end
            S_WAKE: begin
                if (wcnt <= WCW'(1)) state_n = S_CONV;
                else                 wcnt_n  = wcnt - 1'b1;
            end
            S_TRACK: begin
                if (rise) state_n = (low_cnt >= acq_len) ? S_CONV : S_IDLE;
            end
            S_CONV: state_n = S_WAIT;
            S_WAIT: begin
                if (conv_done) begin
                    acc_add = 1'b1;
                    if (acc_last) begin
                        push  = 1'b1;
                        ptr_n = next_req(ch_mask, ptr_inc);
                    end
                    if (mode == MODE_EXT || (acc_last && !more_above)) begin
                        state_n = S_IDLE;
                        finish  = 1'b1;
                    end else begin
                        state_n = S_CONV;
                    end
                end
            end
            default: state_n = S_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state   <= S_IDLE;
            wcnt    <= '0;
            ptr     <= '0;
            eoc_q   <= 1'b0;
            proto_q <= 1'b0;
            cs_prev <= 1'b1;
        end else begin
            state   <= state_n;
            wcnt    <= wcnt_n;
            ptr     <= ptr_n;
            cs_prev <= cs_n;
            proto_q <= fall && !mode[1] && (state != S_IDLE);
            if (finish)
                eoc_q <= 1'b1;
            else if ((!cs_n && cs_prev) || fall)
                eoc_q <= 1'b0;
        end
    end

    // outputs
    always_comb begin
        conv_start = (state == S_CONV);
        conv_ch    = ptr;
        busy       = (state != S_IDLE);
        eoc_n      = !eoc_q;
        proto_err  = proto_q;
    end
endmodule

// File: rtl/adc_scan_seq_chk.sv
module adc_scan_seq_chk #(
    parameter int DEPTH = 8,
    parameter int CW    = 4
) (
    input logic          clk,
    input logic          rst_n,
    input logic [1:0]    mode,
    input logic          cnvst_n,
    input logic          cs_n,
    input logic          conv_start,
    input logic          busy,
    input logic          eoc_n,
    input logic          proto_err,
    input logic [CW-1:0] fifo_count
);
    logic cs_q, cv_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cs_q <= 1'b1;
            cv_q <= 1'b1;
        end else begin
            cs_q <= cs_n;
            cv_q <= cnvst_n;
        end
    end

    // R4: flag holds low without a releasing edge
    p_eoc_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!eoc_n && !(!cs_n && cs_q) && !(!cnvst_n && cv_q)) |=> !eoc_n);

    // R3: conversion request lasts one cycle
    p_conv_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
        conv_start |=> !conv_start);

    // R8: no start out of idle in the strobe-ignoring modes
    p_mode_ext_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (mode[1] && !busy) |=> !busy);

    // R9: error pulse only follows a busy cycle
    p_proto_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
        proto_err |-> $past(busy));

    // R10: occupancy never exceeds the depth
    p_fifo_bound_r10: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_count <= CW'(DEPTH));

    // R11: completion leaves the sequencer idle
    p_idle_at_eoc_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(eoc_n) |-> !busy);
endmodule

bind adc_scan_seq adc_scan_seq_chk #(.DEPTH(FIFO_DEPTH), .CW(FCW)) u_chk (
    .clk(clk), .rst_n(rst_n), .mode(mode), .cnvst_n(cnvst_n), .cs_n(cs_n),
    .conv_start(conv_start), .busy(busy), .eoc_n(eoc_n), .proto_err(proto_err),
    .fifo_count(fifo_count)
);

// File: tb/adc_scan_seq_test.sv
`timescale 1ns/1ps
module adc_scan_seq_test;
    localparam int NCH = 4, DW = 12, DEPTH = 8;
    localparam int MIN_LOW = 3, ACQ = 6, WAKE = 2, REFW = 5, LAT = 3;

    logic       clk = 1'b0, rst_n = 1'b0;
    logic [1:0] mode = 2'b00;
    logic [3:0] ch_mask = 4'hF;
    logic [2:0] avg_sel = 3'd0;
    logic       ref_on = 1'b1, cnvst_n = 1'b1, cs_n = 1'b1, fifo_rd = 1'b0;
    logic       conv_start, conv_done, fifo_empty, eoc_n, busy, proto_err;
    logic [1:0] conv_ch;
    logic [11:0] conv_data, fifo_dout;
    logic [3:0] fifo_count;

    int n_cmp = 0, n_bad = 0;
    int k_stub = 0, k_exp = 0;
    int exp_q [256];
    int eq_wr = 0, eq_rd = 0;
    int lat_cnt = 0;
    logic [1:0] lat_ch = '0;
    bit proto_seen = 0;

    always #2 clk = ~clk;

    adc_scan_seq #(.NCH(NCH), .DW(DW), .FIFO_DEPTH(DEPTH), .MIN_LOW(MIN_LOW),
                   .ACQ_CYC(ACQ), .WAKE_CYC(WAKE), .REF_WAKE_CYC(REFW)) uut (
        .clk(clk), .rst_n(rst_n), .mode(mode), .ch_mask(ch_mask), .avg_sel(avg_sel),
        .ref_on(ref_on), .cnvst_n(cnvst_n), .cs_n(cs_n), .conv_start(conv_start),
        .conv_ch(conv_ch), .conv_done(conv_done), .conv_data(conv_data),
        .fifo_rd(fifo_rd), .fifo_dout(fifo_dout), .fifo_empty(fifo_empty),
        .fifo_count(fifo_count), .eoc_n(eoc_n), .busy(busy), .proto_err(proto_err)
    );

    function automatic int sample(input int ch, input int k);
        return (ch * 1000 + k * 37 + 5) % 4096;
    endfunction

    // converter stand-in: fixed latency, data from channel and sample index
    always @(posedge clk) begin
        conv_done <= 1'b0;
        if (conv_start) begin
            lat_cnt <= LAT;
            lat_ch  <= conv_ch;
        end else if (lat_cnt > 1) begin
            lat_cnt <= lat_cnt - 1;
        end else if (lat_cnt == 1) begin
            lat_cnt   <= 0;
            conv_done <= 1'b1;
            conv_data <= 12'(sample(int'(lat_ch), k_stub));
            k_stub    <= k_stub + 1;
        end
    end

    always @(negedge clk) if (proto_err) proto_seen = 1;

    task automatic report;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int navg(input int sel);
        case (sel)
            1: return 4;
            2: return 8;
            3: return 16;
            4: return 32;
            default: return 1;
        endcase
    endfunction

    task automatic add_entry(input int ch, input int n);
        int sum = 0;
        for (int i = 0; i < n; i++) begin
            sum += sample(ch, k_exp);
            k_exp++;
        end
        if (eq_wr - eq_rd < DEPTH) begin
            exp_q[eq_wr % 256] = (sum / n) % 4096;
            eq_wr++;
        end
    endtask

    task automatic expect_scan(input logic [3:0] m, input int n);
        for (int ch = 0; ch < NCH; ch++)
            if (m[ch]) add_entry(ch, n);
    endtask

    task automatic drain(input string req);
        while (eq_rd < eq_wr) begin
            chk(!fifo_empty && fifo_dout == 12'(exp_q[eq_rd % 256]), req,
                int'(fifo_dout), exp_q[eq_rd % 256]);
            eq_rd++;
            fifo_rd = 1'b1;
            @(negedge clk);
            fifo_rd = 1'b0;
        end
        chk(fifo_empty == 1'b1, req, int'(fifo_empty), 1);
    endtask

    task automatic pulse(input int len);
        @(negedge clk) cnvst_n = 1'b0;
        repeat (len) @(negedge clk);
        cnvst_n = 1'b1;
    endtask

    task automatic wait_eoc(input string req);
        int n = 0;
        while (eoc_n !== 1'b0 && n < 3000) begin
            @(negedge clk);
            n++;
        end
        chk(eoc_n == 1'b0, req, int'(eoc_n), 0);
    endtask

    task automatic release_cs;
        @(negedge clk) cs_n = 1'b0;
        @(negedge clk);
        chk(eoc_n == 1'b1, "R4 cs release", int'(eoc_n), 1);
        cs_n = 1'b1;
    endtask

    task automatic scan00(input logic [3:0] m, input int sel, input bit r, input string req);
        mode = 2'b00; ch_mask = m; avg_sel = 3'(sel); ref_on = r;
        pulse(MIN_LOW);
        wait_eoc(req);
        repeat (3) @(negedge clk);
        chk(eoc_n == 1'b0 && !busy, "R4 hold", int'(eoc_n), 0);
        expect_scan(m, navg(sel));
        release_cs;
        drain(req);
    endtask

    task automatic ext_conv(input int len, input bit accepted);
        @(negedge clk) cnvst_n = 1'b0;
        @(negedge clk);
        chk(eoc_n == 1'b1, "R4 strobe release", int'(eoc_n), 1);
        repeat (len - 1) @(negedge clk);
        cnvst_n = 1'b1;
        if (accepted) begin
            wait_eoc("R5 accepted");
        end else begin
            repeat (15) @(negedge clk);
            chk(eoc_n == 1'b1 && !busy, "R5 short window", int'(busy), 0);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog (all requirements): actual timeout expected completion");
        report;
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(eoc_n == 1'b1, "R1 eoc_n", int'(eoc_n), 1);
        chk(busy == 1'b0, "R1 busy", int'(busy), 0);
        chk(proto_err == 1'b0, "R1 proto_err", int'(proto_err), 0);
        chk(fifo_empty && fifo_count == 0, "R1 fifo", int'(fifo_count), 0);

        // R2 short strobe and empty mask
        mode = 2'b00; ch_mask = 4'hF;
        pulse(MIN_LOW - 1);
        repeat (20) @(negedge clk);
        chk(!busy && fifo_empty, "R2 short strobe", int'(fifo_count), 0);
        ch_mask = 4'h0;
        pulse(MIN_LOW);
        repeat (20) @(negedge clk);
        chk(!busy && fifo_empty, "R2 zero mask", int'(fifo_count), 0);

        // R3 sweep of all masks
        for (int m = 1; m < 16; m++) scan00(4'(m), 0, m[0], "R3 mask sweep");

        // R6 averaging codes
        for (int s = 1; s <= 4; s++) begin
            scan00(4'b1010, s, 1'b1, "R6 average sparse");
            scan00(4'b0001, s, s[0], "R6 average single");
        end
        scan00(4'b0110, 6, 1'b1, "R6 undefined code");

        // R11 wake delay, reference awake and asleep
        for (int r = 0; r < 2; r++) begin
            int n = 0;
            mode = 2'b00; ch_mask = 4'b0001; avg_sel = 3'd0; ref_on = r[0];
            @(negedge clk) cnvst_n = 1'b0;
            repeat (MIN_LOW) @(negedge clk);
            cnvst_n = 1'b1;
            @(negedge clk);
            n = 1;
            chk(busy == 1'b1, "R11 busy", int'(busy), 1);
            while (!conv_start && n < 100) begin
                @(negedge clk);
                n++;
            end
            chk(n == WAKE + (r ? 0 : REFW) + 1, "R11 wake delay", n, WAKE + (r ? 0 : REFW) + 1);
            wait_eoc("R11 done");
            expect_scan(4'b0001, 1);
            release_cs;
            drain("R11 result");
        end

        // R9 strobe while busy
        mode = 2'b00; ch_mask = 4'hF; avg_sel = 3'd2; ref_on = 1'b1;
        proto_seen = 0;
        pulse(MIN_LOW);
        repeat (20) @(negedge clk);
        pulse(MIN_LOW);
        wait_eoc("R9 scan end");
        chk(proto_seen == 1, "R9 error pulse", int'(proto_seen), 1);
        expect_scan(4'hF, 8);
        release_cs;
        drain("R9 intact results");

        // R8 strobe ignored in modes 10 and 11
        for (int md = 2; md < 4; md++) begin
            mode = 2'(md); ch_mask = 4'hF;
            pulse(MIN_LOW);
            repeat (20) @(negedge clk);
            chk(!busy && fifo_empty && eoc_n, "R8 ignored", int'(busy), 0);
        end

        // R5 / R7 per-strobe mode
        mode = 2'b00; repeat (2) @(negedge clk);
        mode = 2'b01; ch_mask = 4'b1010; avg_sel = 3'd0; ref_on = 1'b1;
        repeat (2) @(negedge clk);
        ext_conv(ACQ, 1); add_entry(1, 1);
        ext_conv(ACQ, 1); add_entry(3, 1);
        ext_conv(ACQ, 1); add_entry(1, 1);
        drain("R7 channel order");
        ext_conv(ACQ - 1, 0);
        chk(fifo_empty, "R5 no write", int'(fifo_count), 0);
        ref_on = 1'b0;
        ext_conv(ACQ, 0);
        chk(fifo_empty, "R5 reference window", int'(fifo_count), 0);
        ext_conv(ACQ + REFW, 1); add_entry(3, 1);
        drain("R5 reference accepted");

        // R6 averaging gate in per-strobe mode
        mode = 2'b00; repeat (2) @(negedge clk);
        mode = 2'b01; ch_mask = 4'b0101; avg_sel = 3'd1; ref_on = 1'b1;
        repeat (2) @(negedge clk);
        for (int i = 0; i < 3; i++) ext_conv(ACQ, 1);
        chk(fifo_empty, "R6 gated write", int'(fifo_count), 0);
        ext_conv(ACQ, 1);
        add_entry(0, 4);
        for (int i = 0; i < 4; i++) ext_conv(ACQ, 1);
        add_entry(2, 4);
        chk(fifo_count == 2, "R6 entry count", int'(fifo_count), 2);
        drain("R6 per-strobe average");

        // R10 full FIFO drops new results
        mode = 2'b00; ch_mask = 4'hF; avg_sel = 3'd0;
        repeat (2) @(negedge clk);
        for (int s = 0; s < 3; s++) begin
            pulse(MIN_LOW);
            wait_eoc("R10 scan");
            expect_scan(4'hF, 1);
            release_cs;
        end
        chk(fifo_count == DEPTH, "R10 full count", int'(fifo_count), DEPTH);
        drain("R10 kept entries");
        @(negedge clk) fifo_rd = 1'b1;
        @(negedge clk) fifo_rd = 1'b0;
        chk(fifo_empty && fifo_count == 0, "R10 empty read", int'(fifo_count), 0);

        report;
        $finish;
    end
endmodule